// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block performs the arithmetic part of a general-purpose integer datapath. It adds, subtracts, adds with carry, subtracts with borrow, increments, decrements and negates two's-complement or unsigned operands. The operation can be 8, 16 or 32 bits wide. The result is combinational. Six status flags are held in a register and updated on each accepted operation.

The carry input for add-with-carry and subtract-with-borrow comes from the registered carry flag. This lets multi-word arithmetic be chained one word per cycle. Two dedicated inputs force the registered carry flag high or low.

Subtraction, borrow, decrement and negate all run through one adder, which adds the ones' complement of the subtrahend plus one. The adder's raw carries are then turned into the borrow-style carry and auxiliary flags.

Top module: `flag_alu`

## Requirements
- R1: Operand width is chosen by `size_i`: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits. Result bits above the selected width are zero, and operand bits above it are ignored.
- R2: ADD (op 0) gives a+b. ADC (op 2) gives a+b+CF. For both, CF becomes the carry out of the top bit of the selected width.
- R3: SUB (op 1) gives a−b. SBB (op 3) gives a−b−CF. For both, CF becomes 1 exactly when a is unsigned-smaller than b (plus the incoming CF for SBB).
- R4: OF is set when the signed result does not fit in the selected width.
- R5: AF is set on a carry out of, or a borrow into, bit 4 of the operation.
- R6: SF equals the top bit of the selected width. ZF is set when the selected-width result is zero. PF is set when bits 7:0 of the result hold an even number of ones.
- R7: INC (op 4) gives a+1 and DEC (op 5) gives a−1. Both update OF, SF, ZF, AF and PF, and neither changes CF.
- R8: NEG (op 6) gives 0−a. CF is set for any nonzero a. Negating the most negative value returns that same value with OF set.
- R9: The flags register is `flags_o` = {OF,SF,ZF,AF,PF,CF}, with OF at bit 5 and CF at bit 0. It resets to zero. It loads the new flags on the clock edge after `valid_i` with op 0–6. It holds its value when `valid_i` is low or the op is 7; op 7 also drives `result_o` to zero.
- R10: `stc_i` forces the registered CF to 1 and `clc_i` forces it to 0. Either one overrides the ALU's carry update in the same cycle, and `stc_i` wins when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept the operation this cycle |
| op_i | input | 3 | Operation code (0 ADD, 1 SUB, 2 ADC, 3 SBB, 4 INC, 5 DEC, 6 NEG, 7 none) |
| size_i | input | 2 | Width select |
| a_i | input | 32 | Destination operand |
| b_i | input | 32 | Source operand |
| stc_i | input | 1 | Force carry flag to 1 |
| clc_i | input | 1 | Force carry flag to 0 |
| result_o | output | 32 | Combinational result, zero above width |
| flags_o | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The only internal state is the flags register. Its carry bit feeds straight back into ADC and SBB. A corrupted carry therefore shows up at `result_o` in the first cycle that an ADC or SBB follows it, and in `flags_o` one edge after it was written. The reference model tracks the flags on every clock, so a wrong update is caught at the next comparison rather than only at the end of a chain. Long runs of INC and DEC between carry-consuming ops expose any carry leakage from those operations.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_SIZES = 3;
  localparam int OP_W      = 3;
  localparam int SIZE_W    = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_ADC = 3'd2,
    OP_SBB = 3'd3,
    OP_INC = 3'd4,
    OP_DEC = 3'd5,
    OP_NEG = 3'd6,
    OP_NOP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } alu_flags_t;
endpackage

// File: rtl/alu_add_slice.sv
module alu_add_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o,
  output logic         c4_o
);
  logic [W:0] full;

  assign full   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  // carry into a bit = operand bits xor sum bit
  assign cmsb_o = x_i[W-1] ^ y_i[W-1] ^ full[W-1];
  assign c4_o   = x_i[4] ^ y_i[4] ^ full[4];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import flag_alu_pkg::*;
(
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cf_i,
  output logic [DATA_W-1:0] result_o,
  output alu_flags_t        flags_o,
  output logic              legal_o
);
  logic [DATA_W-1:0] x, y;
  logic              cin, sub_mode, keep_cf;
  logic [DATA_W-1:0] sum_w  [NUM_SIZES];
  logic              cout_w [NUM_SIZES];
  logic              cmsb_w [NUM_SIZES];
  logic              c4_w   [NUM_SIZES];
  logic [1:0]        sel;

  always_comb begin
    x        = a_i;
    y        = b_i;
    cin      = 1'b0;
    sub_mode = 1'b0;
    keep_cf  = 1'b0;
    legal_o  = 1'b1;
    unique case (alu_op_e'(op_i))
      OP_ADD: ;
      OP_SUB: begin y = ~b_i; cin = 1'b1; sub_mode = 1'b1; end
      OP_ADC: cin = cf_i;
      OP_SBB: begin y = ~b_i; cin = ~cf_i; sub_mode = 1'b1; end
      OP_INC: begin y = '0; cin = 1'b1; keep_cf = 1'b1; end
      OP_DEC: begin y = ~DATA_W'(1); cin = 1'b1; sub_mode = 1'b1; keep_cf = 1'b1; end
      OP_NEG: begin x = '0; y = ~a_i; cin = 1'b1; sub_mode = 1'b1; end
      default: legal_o = 1'b0;
    endcase
  end

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_width
    localparam int W = 8 << g;
    logic [W-1:0] s;
    alu_add_slice #(.W(W)) i_slice (
      .x_i   (x[W-1:0]),
      .y_i   (y[W-1:0]),
      .cin_i (cin),
      .sum_o (s),
      .cout_o(cout_w[g]),
      .cmsb_o(cmsb_w[g]),
      .c4_o  (c4_w[g])
    );
    if (W < DATA_W) begin : g_pad
      assign sum_w[g] = {{(DATA_W-W){1'b0}}, s};
    end else begin : g_full
      assign sum_w[g] = s;
    end
  end

  assign sel = (size_i >= 2'd2) ? 2'd2 : size_i;

  always_comb begin
    logic msb;
    result_o = legal_o ? sum_w[sel] : '0;
    unique case (sel)
      2'd0:    msb = result_o[7];
      2'd1:    msb = result_o[15];
      default: msb = result_o[31];
    endcase
    flags_o.cf_f = keep_cf ? cf_i : (cout_w[sel] ^ sub_mode);
    flags_o.of_f = cout_w[sel] ^ cmsb_w[sel];
    flags_o.af_f = c4_w[sel] ^ sub_mode;
    flags_o.sf_f = msb;
    flags_o.zf_f = (result_o == '0);
    flags_o.pf_f = ~^result_o[7:0];
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              stc_i,
  input  logic              clc_i,
  output logic [DATA_W-1:0] result_o,
  output logic [5:0]        flags_o
);
  alu_flags_t flags_q, flags_d, core_flags;
  logic       legal;

  alu_core i_core (
    .op_i    (op_i),
    .size_i  (size_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cf_i    (flags_q.cf_f),
    .result_o(result_o),
    .flags_o (core_flags),
    .legal_o (legal)
  );

  always_comb begin
    flags_d = flags_q;
    if (valid_i && legal) flags_d = core_flags;
    if (stc_i)      flags_d.cf_f = 1'b1;
    else if (clc_i) flags_d.cf_f = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  op_i,
  input logic [1:0]  size_i,
  input logic        stc_i,
  input logic        clc_i,
  input logic [31:0] result_o,
  input logic [5:0]  flags_o
);
  AST_STC_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stc_i |=> flags_o[0]); // R10
  AST_CLC_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clc_i && !stc_i) |=> !flags_o[0]); // R10
  AST_INCDEC_CF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd4 || op_i == 3'd5) && !stc_i && !clc_i)
      |=> flags_o[0] == $past(flags_o[0])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!valid_i || op_i == 3'd7) && !stc_i && !clc_i) |=> $stable(flags_o)); // R9
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0) |-> (result_o[31:8] == 24'h0)); // R1
  AST_ZF_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd7) |=> flags_o[3] == ($past(result_o) == 32'h0)); // R6
  AST_PF_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 3'd7) |=> flags_o[1] == ~^$past(result_o[7:0])); // R6
endmodule

bind flag_alu flag_alu_chk i_flag_alu_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .size_i  (size_i),
  .stc_i   (stc_i),
  .clc_i   (clc_i),
  .result_o(result_o),
  .flags_o (flags_o)
);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        stc_i = 1'b0, clc_i = 1'b0;
  logic [31:0] result_o;
  logic [5:0]  flags_o;

  int n_cmp = 0, n_bad = 0;
  logic [5:0] m_flags = '0;   // model of register, bit order {OF,SF,ZF,AF,PF,CF}
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  flag_alu i_flag_alu (.*);

  task automatic cmp(input string req, input string what,
                     input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural model: returns result, writes next flags
  function automatic longint unsigned model(input int op, input int sz,
      input longint unsigned a0, input longint unsigned b0,
      input logic [5:0] fin, output logic [5:0] fout);
    int w;
    longint unsigned mask, a, b, r, c;
    longint sa, sb, s, lo, hi;
    logic cf, of_, af, sf, zf, pf;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    a = a0 & mask; b = b0 & mask;
    sa = (a >> (w-1)) ? longint'(a) - longint'(mask) - 1 : longint'(a);
    sb = (b >> (w-1)) ? longint'(b) - longint'(mask) - 1 : longint'(b);
    c  = fin[0];
    cf = fin[0]; af = 0; s = 0; r = 0;
    case (op)
      0, 2: begin
        if (op == 0) c = 0;
        r = a + b + c; cf = (r >> w) & 1; s = sa + sb + longint'(c);
        af = ((a & 15) + (b & 15) + c) > 15;
      end
      1, 3: begin
        if (op == 1) c = 0;
        r = a - b - c; cf = a < b + c; s = sa - sb - longint'(c);
        af = (a & 15) < (b & 15) + c;
      end
      4: begin r = a + 1; s = sa + 1; af = (a & 15) == 15; end
      5: begin r = a - 1; s = sa - 1; af = (a & 15) == 0; end
      6: begin r = -a; s = -sa; cf = a != 0; af = (a & 15) != 0; end
      default: begin fout = fin; return 0; end
    endcase
    r  = r & mask;
    lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1;
    of_ = (s < lo) || (s > hi);
    sf = (r >> (w-1)) & 1;
    zf = r == 0;
    pf = ($countones(r & 255) % 2) == 0;
    fout = {of_, sf, zf, af, pf, cf};
    return r;
  endfunction

  // one cycle: check register state, drive, check result, advance model
  task automatic step(input string req, input bit v, input int op, input int sz,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit st = 0, input bit cl = 0);
    logic [5:0] nf;
    longint unsigned r;
    @(negedge clk_i);
    cmp(req, "flags", flags_o, m_flags);
    valid_i = v; op_i = 3'(op); size_i = 2'(sz); a_i = a; b_i = b;
    stc_i = st; clc_i = cl;
    #2;
    r = model(op, sz, a, b, m_flags, nf);
    cmp(req, "result", result_o, r);
    if (!v) nf = m_flags;
    if (st) nf[0] = 1'b1; else if (cl) nf[0] = 1'b0;
    m_flags = nf;
  endtask

  initial begin
    #55;
    cmp("R9", "reset flags", flags_o, 6'h0);
    rst_ni = 1'b1;
    // R2 / R6 worked case: 8-bit FF+1
    step("R2", 1, 0, 0, 32'hFF, 32'h1);
    step("R4", 1, 0, 0, 32'h7F, 32'h1);         // 7F+1 -> 80, OF
    step("R3", 1, 1, 0, 32'h0, 32'h1);          // 00-1 borrow
    step("R3", 1, 1, 0, 32'h26, 32'h95);
    step("R5", 1, 0, 1, 32'h000F, 32'h0001);
    step("R1", 1, 0, 0, 32'hABCD_12FF, 32'h5555_0001); // upper bits ignored
    step("R1", 1, 0, 3, 32'hFFFF_FFFF, 32'h1);  // size 3 = 32 bits
    // carry chain
    step("R10", 0, 0, 0, 0, 0, 1, 0);
    step("R2", 1, 2, 2, 32'hFFFF_FFFF, 32'h0);  // ADC with CF=1
    step("R2", 1, 2, 2, 32'h1, 32'h1);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R3", 1, 3, 1, 32'h0, 32'h0);          // SBB CF=0
    step("R10", 1, 0, 0, 32'hFF, 32'h1, 0, 1);  // clear overrides ALU carry
    step("R10", 1, 1, 0, 32'h5, 32'h1, 1, 0);   // set overrides
    step("R10", 0, 0, 0, 0, 0, 1, 1);           // set wins
    step("R3", 1, 3, 0, 32'h10, 32'h0F);        // SBB with CF=1
    // R7 INC/DEC keep CF
    step("R7", 1, 4, 0, 32'hFF, 0);
    step("R7", 1, 5, 0, 32'h00, 0);
    step("R7", 1, 4, 0, 32'h7F, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R7", 1, 5, 2, 32'h8000_0000, 0);
    // R8 NEG
    step("R8", 1, 6, 0, 32'h80, 0);
    step("R8", 1, 6, 1, 32'h0, 0);
    step("R8", 1, 6, 2, 32'h8000_0000, 0);
    step("R8", 1, 6, 1, 32'h1234, 0);
    // R9 hold
    step("R9", 0, 0, 0, 32'h0, 32'h0);
    step("R9", 1, 7, 0, 32'hFF, 32'h1);
    step("R9", 1, 7, 2, 32'h1, 32'h2);
    // R6 parity on low byte only at wide width
    step("R6", 1, 0, 1, 32'h0300, 32'h0003);
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 7);
      step("R2-random", ($urandom_range(0, 3) != 0), op, $urandom_range(0, 3),
           $urandom(), (i % 5 == 0) ? 32'h0 : $urandom(),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
    end
    step("R9", 0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule